// File: doc/BRIEF.md
# Game Controller Serial Button Responder

This block is the controller end of a three-wire button link: a host drives a latch line and a bus clock, and the block answers on one data line. A rising latch takes a snapshot of the twelve button inputs. When the latch falls, the first bit of that snapshot appears on the data line. Each rising bus-clock edge after that moves the line on to the next bit. After sixteen bits the line is driven low and stays low until the next latch.

The latch and bus clock come from another clock domain. Each passes through a synchronizer and an edge detector running on the fast system clock, so the system clock must run at least eight times the bus-clock rate. The block suits emulated or replacement controllers built inside a larger device.

Top module: `pad_shift_responder`

## Requirements
- R1: The twelve button inputs are captured on a rising latch edge. Button changes after that edge do not alter the bits sent in that frame.
- R2: Frame bit k (k = 0..11) carries button input k, inverted: a pressed button (input 1) is sent as 0. Bit 0 is sent first. Inputs 0..11 are B, Y, Select, Start, Up, Down, Left, Right, A, X, L, R.
- R3: Frame bits 12 to 15 are always sent as 1.
- R4: Bit 0 is driven onto the data line when the latch falls, before any bus-clock edge.
- R5: Each rising bus-clock edge moves the data line to the next frame bit. Falling bus-clock edges leave it unchanged.
- R6: The rising bus-clock edge after bit 15 drives the data line low. It stays low through any further bus-clock edges until the next rising latch edge.
- R7: While the latch is high, the data line is low and bus-clock edges do not advance the frame.
- R8: A rising latch edge in the middle of a frame takes a new snapshot and restarts the frame at bit 0.
- R9: After reset the data line is low. Bus-clock edges seen before the first latch have no effect.
- R10: The data line answers a latch or bus-clock edge on the third system-clock edge after the input changes: two synchronizer stages, then one state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| latch_in | input | 1 | Asynchronous snapshot request from the host |
| bus_clk_in | input | 1 | Asynchronous bit clock from the host, idles high |
| buttons_i | input | 12 | Button states, 1 = pressed, index 0 = B |
| data_out | output | 1 | Serial button data to the host |

## Verification
The frame is exercised with four button patterns: none pressed, all pressed, only B pressed, and an irregular mix. These separate an inversion fault, a bit-order fault and a fault in the fill bits. Other runs check specific behaviours:
- Buttons are changed in mid-frame to show the snapshot is held.
- Clock pulses are sent before any latch and while the latch is high.
- Extra clock pulses are sent after the sixteenth bit.
- A second latch arrives partway through a frame, with a different pattern, to show the bit counter restarts.

// File: rtl/pad_resp_pkg.sv
package pad_resp_pkg;

    localparam int DEF_KEYS        = 12;
    localparam int DEF_FRAME_BITS  = 16;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_SHIFT = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_ev_t;

endpackage

// File: rtl/pad_edge_sync.sv
module pad_edge_sync
    import pad_resp_pkg::*;
#(
    parameter int   STAGES   = DEF_SYNC_STAGES,
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     async_in,
    output edge_ev_t ev
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE_VAL}};
            prev_q  <= IDLE_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        ev.level = chain_q[STAGES-1];
        ev.rise  = chain_q[STAGES-1] & ~prev_q;
        ev.fall  = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/pad_frame_shifter.sv
module pad_frame_shifter
    import pad_resp_pkg::*;
#(
    parameter int KEYS       = DEF_KEYS,
    parameter int FRAME_BITS = DEF_FRAME_BITS,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  edge_ev_t              lat_ev,
    input  edge_ev_t              bclk_ev,
    input  logic [KEYS-1:0]       keys,
    output phase_t                phase,
    output logic [FRAME_BITS-1:0] word,
    output logic [CNT_W-1:0]      pos,
    output logic                  dout
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] frame_d;

    // Active-low button bits first, then fill bits that read as released.
    for (genvar i = 0; i < FRAME_BITS; i++) begin : g_frame
        if (i < KEYS) begin : g_key
            assign frame_d[i] = ~keys[i];
        end else begin : g_fill
            assign frame_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            word  <= '0;
            pos   <= '0;
        end else if (lat_ev.rise) begin
            phase <= PH_HOLD;
            word  <= frame_d;
            pos   <= '0;
        end else begin
            case (phase)
                PH_HOLD: begin
                    if (lat_ev.fall) phase <= PH_SHIFT;
                end
                PH_SHIFT: begin
                    if (bclk_ev.rise) begin
                        if (pos == LAST_POS) begin
                            phase <= PH_DONE;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                        word <= {1'b0, word[FRAME_BITS-1:1]};
                    end
                end
                default: ;
            endcase
        end
    end

    assign dout = (phase == PH_SHIFT) ? word[0] : 1'b0;
endmodule

// File: rtl/pad_shift_responder.sv
module pad_shift_responder
    import pad_resp_pkg::*;
#(
    parameter int KEYS        = DEF_KEYS,
    parameter int FRAME_BITS  = DEF_FRAME_BITS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            latch_in,
    input  logic            bus_clk_in,
    input  logic [KEYS-1:0] buttons_i,
    output logic            data_out
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    edge_ev_t              lat_ev;
    edge_ev_t              bclk_ev;
    phase_t                phase;
    logic [FRAME_BITS-1:0] word;
    logic [CNT_W-1:0]      pos;

    pad_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b0)) u_lat_sync (
        .clk(clk), .rst(rst), .async_in(latch_in), .ev(lat_ev)
    );

    pad_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_bclk_sync (
        .clk(clk), .rst(rst), .async_in(bus_clk_in), .ev(bclk_ev)
    );

    pad_frame_shifter #(.KEYS(KEYS), .FRAME_BITS(FRAME_BITS)) u_shift (
        .clk(clk), .rst(rst), .lat_ev(lat_ev), .bclk_ev(bclk_ev),
        .keys(buttons_i), .phase(phase), .word(word), .pos(pos),
        .dout(data_out)
    );
endmodule

// File: rtl/pad_resp_checker.sv
module pad_resp_checker
    import pad_resp_pkg::*;
#(
    parameter int KEYS       = DEF_KEYS,
    parameter int FRAME_BITS = DEF_FRAME_BITS,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  lat_rise,
    input logic                  lat_fall,
    input logic                  bclk_rise,
    input logic [KEYS-1:0]       keys,
    input phase_t                phase,
    input logic [FRAME_BITS-1:0] word,
    input logic [CNT_W-1:0]      pos,
    input logic                  data_out
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

    AST_SNAPSHOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        lat_rise |=> (word[KEYS-1:0] == ~$past(keys)) && (pos == '0)); // R1

    AST_FILL_HIGH: assert property (@(posedge clk) disable iff (rst)
        lat_rise |=> (word[FRAME_BITS-1:KEYS] == '1)); // R3

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD) |-> !data_out); // R7

    AST_NO_SHIFT_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SHIFT && !bclk_rise && !lat_rise) |=> $stable(data_out) && $stable(pos)); // R5

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SHIFT && bclk_rise && !lat_rise && pos != LAST_POS)
        |=> (pos == $past(pos) + 1'b1)); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE && !lat_rise) |=> (phase == PH_DONE) && !data_out); // R6

    AST_FIRST_BIT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && lat_fall && !lat_rise) |=> (data_out == $past(word[0]))); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !lat_rise) |=> (phase == PH_IDLE) && !data_out); // R9
endmodule

bind pad_shift_responder pad_resp_checker #(.KEYS(KEYS), .FRAME_BITS(FRAME_BITS)) u_chk (
    .clk(clk), .rst(rst), .lat_rise(lat_ev.rise), .lat_fall(lat_ev.fall),
    .bclk_rise(bclk_ev.rise), .keys(buttons_i), .phase(phase), .word(word),
    .pos(pos), .data_out(data_out)
);

// File: tb/pad_shift_responder_bench.sv
module pad_shift_responder_bench;

    typedef struct {
        logic  val;
        string tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        latch_in = 1'b0;
    logic        bus_clk_in = 1'b1;
    logic [11:0] buttons_i = '0;
    logic        data_out;

    int        checks = 0;
    int        errors = 0;
    exp_item_t exp_q[$];
    event      sample_ev;
    logic [11:0] frame_keys;

    always #4 clk = ~clk;

    pad_shift_responder u_pad_shift_responder (
        .clk(clk), .rst(rst), .latch_in(latch_in), .bus_clk_in(bus_clk_in),
        .buttons_i(buttons_i), .data_out(data_out)
    );

    // Monitor: pops the next expectation and compares it with the pin.
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                checks++;
                if (data_out !== it.val) begin
                    errors++;
                    $display("FAIL %s: data_out=%b expected=%b at %0t", it.tag, data_out, it.val, $time);
                end
            end
        end
    end

    function automatic logic model_bit(input logic [11:0] k, input int idx);
        if (idx >= 16) return 1'b0;   // R6
        if (idx >= 12) return 1'b1;   // R3
        return ~k[idx];               // R2
    endfunction

    task automatic expect_now(input logic v, input string tag);
        exp_item_t it;
        it.val = v;
        it.tag = tag;
        exp_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic latch_pulse(input logic [11:0] keys);
        @(negedge clk);
        buttons_i  = keys;
        frame_keys = keys;
        latch_in   = 1'b1;
        wait_sys(4);
        expect_now(1'b0, "R7");
        wait_sys(4);
        latch_in = 1'b0;
        wait_sys(2);
        expect_now(1'b0, "R10");   // still in synchronizer
        wait_sys(1);
        expect_now(model_bit(keys, 0), "R4");
    endtask

    // One bus clock period; idx is the bit expected after the rising edge.
    task automatic bus_pulse(input int idx, input string tag);
        @(negedge clk);
        bus_clk_in = 1'b0;
        wait_sys(4);
        expect_now(model_bit(frame_keys, idx - 1), "R5");
        wait_sys(2);
        bus_clk_in = 1'b1;
        wait_sys(4);
        expect_now(model_bit(frame_keys, idx), tag);
        wait_sys(2);
    endtask

    task automatic full_frame(input logic [11:0] keys);
        latch_pulse(keys);
        for (int k = 1; k <= 16; k++) begin
            bus_pulse(k, (k >= 16) ? "R6" : (k >= 12) ? "R3" : "R2");
        end
    endtask

    initial begin
        frame_keys = '0;
        wait_sys(4);
        rst = 1'b0;
        wait_sys(2);
        expect_now(1'b0, "R9");

        // Clocks before any latch: stays low
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); bus_clk_in = 1'b0; wait_sys(6);
            bus_clk_in = 1'b1; wait_sys(4);
            expect_now(1'b0, "R9");
        end

        full_frame(12'h000);
        full_frame(12'hFFF);
        full_frame(12'h001);
        full_frame(12'hA5C);

        // R1: buttons change mid-frame, frame holds snapshot
        latch_pulse(12'h3C6);
        buttons_i = 12'hC39;
        for (int k = 1; k <= 16; k++) bus_pulse(k, "R1");

        // R6: extra clocks after the end of frame
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); bus_clk_in = 1'b0; wait_sys(6);
            bus_clk_in = 1'b1; wait_sys(4);
            expect_now(1'b0, "R6");
        end

        // R7: clocks while latch high do not advance
        @(negedge clk);
        buttons_i  = 12'h0F0;
        frame_keys = 12'h0F0;
        latch_in   = 1'b1;
        wait_sys(6);
        for (int k = 0; k < 2; k++) begin
            bus_clk_in = 1'b0; wait_sys(6);
            bus_clk_in = 1'b1; wait_sys(4);
            expect_now(1'b0, "R7");
        end
        latch_in = 1'b0;
        wait_sys(4);
        expect_now(model_bit(frame_keys, 0), "R7");
        for (int k = 1; k <= 16; k++) bus_pulse(k, "R7");

        // R8: relatch mid-frame restarts
        latch_pulse(12'h555);
        for (int k = 1; k <= 5; k++) bus_pulse(k, "R8");
        latch_pulse(12'h00E);
        for (int k = 1; k <= 16; k++) bus_pulse(k, "R8");

        wait_sys(4);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5: pending=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL R10: watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule